// File: doc/BRIEF.md
# USB Line Monitor

This block listens to a low-speed or full-speed USB differential pair and condenses what it sees into one 32-bit status word. A fractional phase accumulator produces one sampling tick per bit time. At each tick the pair is classified as J, K, single-ended zero (SE0) or single-ended one (SE1). Packets are framed by a sync pattern and an end-of-packet, and between them the data is NRZI-decoded, stripped of stuffed bits and packed into bytes.

Software may read the status word at any moment. There is no per-byte handshake and therefore no back-pressure. A reader spots new bytes by watching a toggle bit flip, and watches line conditions through flags that require a minimum duration. A sticky change flag tells the reader that the word differs from before. The flag stays high until the reader acknowledges it. The speed input mirrors the meaning of J and K.

Top module: `usbrx_line_monitor`

## Requirements
- R1: `status_word` has bits [31:16] always zero, [15:8] the most recent byte received, bit 7 byte toggle, bit 6 error, bit 5 end-of-packet seen, bit 4 start-of-packet seen, bit 3 SE1 flag, bit 2 SE0 flag, bit 1 K flag, bit 0 J flag. All bits are zero after reset.
- R2: A start-of-packet clears the byte toggle. Each completed byte inverts the toggle and loads bits [15:8].
- R3: A start-of-packet is recognised when a J sample is followed by the samples K J K J K J K K. It sets bit 4 and clears bits 5, 6 and 7.
- R4: Inside a packet, one or more SE0 samples followed by a non-SE0 sample end the packet. This sets bit 5 and clears bit 4.
- R5: The error bit is set by any of three causes: a seventh identical level after six decoded 1s (a stuffing violation), an end-of-packet whose SE0 spans more than 3 samples, or any SE1 sample. Only a start-of-packet clears it.
- R6: Each of the J, K and SE0 flags is 1 when its line state has been sampled 7 or more times in a row, including the current sample. The flag clears at the first sample of a different state.
- R7: The SE1 flag is 1 exactly while the latest sample is SE1.
- R8: `status_changed` rises one cycle after any bit of the status word changes. It holds until `status_ack` is high in a cycle in which no new change occurs.
- R9: Data bits are NRZI-decoded: the same level as the previous sample is a 1, and a level change is a 0. Bytes are assembled LSB first. The sample that follows six consecutive 1s is discarded when it is a level change.
- R10: Each clock, the 16-bit `baud_inc` is added to a phase accumulator, and a carry out yields a sample tick. Any change of the line state reloads the phase to one half (0x8000), so the next sample falls mid-bit. With `baud_inc` = 0 no samples occur and the status word holds.
- R11: With `full_speed` = 1, J is `line_dp`=1, `line_dm`=0. With `full_speed` = 0, J is `line_dp`=0, `line_dm`=1. K is the opposite of J, and both lines low is SE0, both high is SE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_speed | input | 1 | 1 = full-speed J/K polarity, 0 = low-speed polarity |
| baud_inc | input | 16 | Per-clock phase increment, fraction of the clock rate |
| line_dp | input | 1 | Positive data line, synchronous to clk |
| line_dm | input | 1 | Negative data line, synchronous to clk |
| status_ack | input | 1 | Clears the change flag |
| status_word | output | 32 | Receiver status word |
| status_changed | output | 1 | Sticky change-of-status flag |

## Verification
Most internal faults become visible at a packet's boundaries.
- A misaligned accumulator or a wrong stuff counter corrupts bits [15:8] or leaves the toggle parity wrong once the packet's last byte is complete. That is within one bit time of the final data bit.
- A framing fault shows as a wrong bit 4/bit 5 pair, or a missing error bit, a few samples after the end-of-packet.
- A wrong run counter moves the line flags by whole bit times. The bench therefore samples at the sixth and seventh identical bit.
- A lost change flag is visible one cycle after any word change.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  localparam int BYTE_W  = 8;
  localparam int NBIT_W  = $clog2(BYTE_W);
  localparam int STAT_W  = 32;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'd0,
    SYM_K   = 2'd1,
    SYM_J   = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_t;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic              byte_valid;
    logic              err;
    logic [BYTE_W-1:0] data;
  } rx_evt_t;

  function automatic line_sym_t classify(input logic dp, input logic dm, input logic fs);
    if (dp == dm) return dp ? SYM_SE1 : SYM_SE0;
    return (dp == fs) ? SYM_J : SYM_K;
  endfunction

endpackage

// File: rtl/usbrx_baud_nco.sv
module usbrx_baud_nco #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] inc,
  input  logic         realign,
  output logic         tick
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] phase;
  logic [W:0]   sum;

  assign sum = {1'b0, phase} + {1'b0, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      tick  <= 1'b0;
    end else if (realign) begin
      phase <= HALF;
      tick  <= 1'b0;
    end else begin
      phase <= sum[W-1:0];
      tick  <= sum[W];
    end
  end

  // R10: a line edge suppresses the next tick (sample moved to mid-bit)
  a_r10_realign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !tick);

  // R10: no increment, no sample tick
  a_r10_zero_inc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0) && (phase < HALF) |=> !tick);

endmodule

// File: rtl/usbrx_bit_engine.sv
module usbrx_bit_engine
  import usbrx_pkg::*;
#(
  parameter int STUFF_RUN   = 6,
  parameter int EOP_MAX_SE0 = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  line_sym_t sym,
  output rx_evt_t   evt
);
  localparam int HIST_SYMS = 9;
  localparam int HW        = 2 * HIST_SYMS;
  localparam int OW        = $clog2(STUFF_RUN + 1);
  localparam int SW        = $clog2(EOP_MAX_SE0 + 2);
  localparam logic [OW-1:0]     STUFF_LIM = OW'(STUFF_RUN);
  localparam logic [SW-1:0]     EOP_LIM   = SW'(EOP_MAX_SE0);
  localparam logic [NBIT_W-1:0] LAST_BIT  = NBIT_W'(BYTE_W - 1);
  localparam logic [HW-1:0]     SYNC_PAT  = {SYM_J, SYM_K, SYM_J, SYM_K, SYM_J,
                                             SYM_K, SYM_J, SYM_K, SYM_K};

  typedef enum logic [1:0] {ST_HUNT, ST_DATA, ST_EOP} eng_state_t;

  eng_state_t        state;
  logic [HW-1:0]     hist;
  logic [HW-1:0]     hist_next;
  line_sym_t         level;
  logic [OW-1:0]     ones;
  logic [NBIT_W-1:0] nbit;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] byte_next;
  logic [SW-1:0]     se0_len;
  logic              bit_now;

  always_comb begin
    hist_next = {hist[HW-3:0], sym};
    bit_now   = (sym == level);
    byte_next = {bit_now, shreg[BYTE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      hist    <= '0;
      level   <= SYM_J;
      ones    <= '0;
      nbit    <= '0;
      shreg   <= '0;
      se0_len <= '0;
      evt     <= '0;
    end else begin
      evt <= '0;
      if (tick) begin
        hist <= hist_next;
        case (state)
          ST_HUNT: begin
            if (hist_next == SYNC_PAT) begin
              evt.sop <= 1'b1;
              state   <= ST_DATA;
              level   <= SYM_K;
              ones    <= OW'(1);
              nbit    <= '0;
            end
          end
          ST_DATA: begin
            case (sym)
              SYM_SE0: begin
                state   <= ST_EOP;
                se0_len <= SW'(1);
              end
              SYM_SE1: state <= ST_HUNT;
              default: begin
                level <= sym;
                if (ones == STUFF_LIM) begin
                  if (bit_now) begin
                    evt.err <= 1'b1;
                    state   <= ST_HUNT;
                  end
                  ones <= '0;
                end else begin
                  ones  <= bit_now ? ones + 1'b1 : '0;
                  shreg <= byte_next;
                  nbit  <= nbit + 1'b1;
                  if (nbit == LAST_BIT) begin
                    evt.byte_valid <= 1'b1;
                    evt.data       <= byte_next;
                  end
                end
              end
            endcase
          end
          ST_EOP: begin
            if (sym == SYM_SE0) begin
              if (se0_len != '1) se0_len <= se0_len + 1'b1;
            end else begin
              evt.eop <= 1'b1;
              evt.err <= (se0_len > EOP_LIM);
              state   <= ST_HUNT;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  // R3/R4: framing events never coincide
  a_r3_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.sop, evt.eop, evt.byte_valid}));

  // R4: an end-of-packet only follows the SE0 phase
  a_r4_eop_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
    evt.eop |-> $past(state == ST_EOP));

  // R9: the run of decoded ones never passes the stuffing limit
  a_r9_stuff_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= STUFF_LIM);

endmodule

// File: rtl/usbrx_status_reg.sv
module usbrx_status_reg
  import usbrx_pkg::*;
#(
  parameter int RUN_MIN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  line_sym_t         sym,
  input  rx_evt_t           evt,
  input  logic              ack,
  output logic [STAT_W-1:0] status,
  output logic              changed
);
  localparam int CW = $clog2(RUN_MIN + 1);
  localparam logic [CW-1:0] RUN_LIM = CW'(RUN_MIN);

  line_sym_t         last;
  logic [CW-1:0]     run;
  logic [CW-1:0]     run_next;
  logic [BYTE_W-1:0] byte_q;
  logic              tog, err, eop, sop, se1, se0, kf, jf;
  logic [STAT_W-1:0] prev;

  always_comb begin
    if (sym != last)         run_next = CW'(1);
    else if (run >= RUN_LIM) run_next = run;
    else                     run_next = run + 1'b1;
  end

  assign status = {{(STAT_W-16){1'b0}}, byte_q, tog, err, eop, sop, se1, se0, kf, jf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last <= SYM_SE0;
      run  <= '0;
      se1  <= 1'b0;
      se0  <= 1'b0;
      kf   <= 1'b0;
      jf   <= 1'b0;
    end else if (tick) begin
      last <= sym;
      run  <= run_next;
      se1  <= (sym == SYM_SE1);
      se0  <= (sym == SYM_SE0) && (run_next >= RUN_LIM);
      kf   <= (sym == SYM_K)   && (run_next >= RUN_LIM);
      jf   <= (sym == SYM_J)   && (run_next >= RUN_LIM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      tog    <= 1'b0;
      err    <= 1'b0;
      eop    <= 1'b0;
      sop    <= 1'b0;
    end else begin
      if (evt.sop) begin
        tog <= 1'b0;
        err <= 1'b0;
        eop <= 1'b0;
        sop <= 1'b1;
      end
      if (evt.byte_valid) begin
        byte_q <= evt.data;
        tog    <= ~tog;
      end
      if (evt.eop) begin
        eop <= 1'b1;
        sop <= 1'b0;
      end
      if (evt.err || (tick && sym == SYM_SE1)) err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      changed <= 1'b0;
    end else begin
      prev <= status;
      if (status != prev) changed <= 1'b1;
      else if (ack)       changed <= 1'b0;
    end
  end

  // R6/R7: at most one line-state flag is up
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[3:0]));

  // R4: packet-open and packet-closed are never both reported
  a_r4_sop_eop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[5] && status[4]));

  // R2: toggle moves only on a byte or a start-of-packet
  a_r2_toggle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] != $past(status[7])) |-> $past(evt.sop || evt.byte_valid));

  // R8: a word change raises the flag on the next cycle
  a_r8_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (status != $past(status)) |=> changed);

  // R8: unacknowledged flag is held
  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && !ack) |=> changed);

endmodule

// File: rtl/usbrx_line_monitor.sv
module usbrx_line_monitor
  import usbrx_pkg::*;
#(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_speed,
  input  logic [BAUD_W-1:0] baud_inc,
  input  logic              line_dp,
  input  logic              line_dm,
  input  logic              status_ack,
  output logic [STAT_W-1:0] status_word,
  output logic              status_changed
);
  line_sym_t raw_sym;
  line_sym_t raw_q;
  logic      realign;
  logic      tick;
  rx_evt_t   evt;

  assign raw_sym = classify(line_dp, line_dm, full_speed);
  assign realign = (raw_sym != raw_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= SYM_SE0;
    else        raw_q <= raw_sym;
  end

  usbrx_baud_nco #(.W(BAUD_W)) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (baud_inc),
    .realign (realign),
    .tick    (tick)
  );

  usbrx_bit_engine u_engine (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .sym   (raw_sym),
    .evt   (evt)
  );

  usbrx_status_reg u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sym     (raw_sym),
    .evt     (evt),
    .ack     (status_ack),
    .status  (status_word),
    .changed (status_changed)
  );

endmodule

// File: tb/tb_usbrx_line_monitor.sv
module tb_usbrx_line_monitor;

  localparam int L_SE0 = 0;
  localparam int L_K   = 1;
  localparam int L_J   = 2;
  localparam int L_SE1 = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        full_speed = 1'b1;
  logic [15:0] baud_inc = 16'h4000;
  logic        line_dp = 1'b1;
  logic        line_dm = 1'b0;
  logic        status_ack = 1'b0;
  logic [31:0] status_word;
  logic        status_changed;

  int errs = 0;
  int checks = 0;
  int bit_cyc = 4;
  int level = L_K;
  int ones = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  usbrx_line_monitor dut (
    .clk(clk), .rst_n(rst_n), .full_speed(full_speed), .baud_inc(baud_inc),
    .line_dp(line_dp), .line_dm(line_dm), .status_ack(status_ack),
    .status_word(status_word), .status_changed(status_changed)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_line(input int s);
    case (s)
      L_SE0: begin line_dp = 1'b0; line_dm = 1'b0; end
      L_SE1: begin line_dp = 1'b1; line_dm = 1'b1; end
      L_J:   begin line_dp = full_speed;  line_dm = ~full_speed; end
      default: begin line_dp = ~full_speed; line_dm = full_speed; end
    endcase
  endtask

  task automatic drive(input int s, input int n);
    set_line(s);
    repeat (n * bit_cyc) @(negedge clk);
  endtask

  task automatic send_sync();
    drive(L_J, 2);
    for (int i = 0; i < 3; i++) begin drive(L_K, 1); drive(L_J, 1); end
    drive(L_K, 2);
    level = L_K;
    ones = 1;
  endtask

  task automatic send_bit(input bit b);
    if (b) ones++;
    else begin level = (level == L_J) ? L_K : L_J; ones = 0; end
    drive(level, 1);
    if (ones == 6) begin
      level = (level == L_J) ? L_K : L_J;
      ones = 0;
      drive(level, 1);
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_eop(input int se0_n);
    drive(L_SE0, se0_n);
    drive(L_J, 10);
  endtask

  function automatic logic [31:0] done_word(input logic [7:0] last, input int n, input bit err);
    return {16'h0, last, 1'(n % 2), err, 1'b1, 1'b0, 4'b0001};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    set_line(L_J);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", status_word, 32'h0);
    chk("R8 reset flag", {31'h0, status_changed}, 32'h0);
  endtask

  task automatic t_line_flags();
    drive(L_J, 10);
    chk("R6 J after idle", status_word, 32'h1);
    drive(L_K, 6);
    chk("R6 six K samples", status_word & 32'hF, 32'h0);
    drive(L_K, 1);
    chk("R6 seven K samples", status_word & 32'hF, 32'h2);
    drive(L_SE0, 8);
    chk("R6 SE0 flag", status_word & 32'hF, 32'h4);
    drive(L_SE1, 1);
    chk("R7 SE1 flag", status_word & 32'hF, 32'h8);
    chk("R5 SE1 sets error", status_word & 32'h40, 32'h40);
    drive(L_J, 10);
    chk("R7 SE1 cleared", status_word & 32'hF, 32'h1);
    chk("R5 error sticky", status_word & 32'h40, 32'h40);
  endtask

  task automatic t_basic_packet();
    send_sync();
    send_byte(8'hA5);
    @(negedge clk);
    chk("R3 R2 mid packet", status_word & 32'hFFF0, {16'h0, 8'hA5, 4'b1001, 4'h0});
    send_byte(8'h0F);
    send_eop(2);
    chk("R4 R9 end of packet", status_word, done_word(8'h0F, 2, 1'b0));
  endtask

  task automatic t_stuffing();
    send_sync();
    send_byte(8'hFF);
    send_byte(8'hFF);
    send_byte(8'h7E);
    send_eop(2);
    chk("R9 stuffed bytes", status_word, done_word(8'h7E, 3, 1'b0));
  endtask

  task automatic t_unstuff_err();
    send_sync();
    drive(L_K, 7);
    send_eop(2);
    chk("R5 stuffing violation", status_word & 32'h40, 32'h40);
  endtask

  task automatic t_long_eop();
    send_sync();
    send_byte(8'h12);
    send_eop(5);
    chk("R5 long end of packet", status_word, done_word(8'h12, 1, 1'b1));
  endtask

  task automatic t_low_speed();
    full_speed = 1'b0;
    drive(L_J, 10);
    chk("R11 low-speed idle pins", {30'h0, line_dp, line_dm}, 32'h1);
    chk("R11 low-speed J flag", status_word & 32'hF, 32'h1);
    send_sync();
    send_byte(8'h3C);
    send_byte(8'h81);
    send_eop(2);
    chk("R11 low-speed packet", status_word, done_word(8'h81, 2, 1'b0));
    full_speed = 1'b1;
    drive(L_J, 10);
  endtask

  task automatic t_odd_rate();
    baud_inc = 16'h3333;
    bit_cyc = 5;
    drive(L_J, 10);
    send_sync();
    send_byte(8'h5A);
    send_byte(8'hC3);
    send_byte(8'hE7);
    send_eop(2);
    chk("R10 odd-ratio packet", status_word, done_word(8'hE7, 3, 1'b0));
    baud_inc = 16'h4000;
    bit_cyc = 4;
    drive(L_J, 10);
  endtask

  task automatic t_change_flag();
    logic [31:0] snap;
    status_ack = 1'b1;
    @(negedge clk);
    status_ack = 1'b0;
    drive(L_J, 3);
    chk("R8 quiet after ack", {31'h0, status_changed}, 32'h0);
    drive(L_K, 1);
    drive(L_J, 3);
    chk("R8 raised and held", {31'h0, status_changed}, 32'h1);
    status_ack = 1'b1;
    @(negedge clk);
    status_ack = 1'b0;
    @(negedge clk);
    chk("R8 cleared by ack", {31'h0, status_changed}, 32'h0);
    drive(L_J, 8);
    snap = status_word;
    chk("R6 J back after K", snap & 32'hF, 32'h1);
  endtask

  task automatic t_zero_rate();
    logic [31:0] snap;
    snap = status_word;
    baud_inc = 16'h0;
    drive(L_K, 10);
    chk("R10 zero increment holds word", status_word, snap);
    baud_inc = 16'h4000;
    drive(L_K, 8);
    chk("R10 sampling resumes", status_word & 32'hF, 32'h2);
    drive(L_J, 10);
  endtask

  initial begin
    t_reset();
    t_line_flags();
    t_basic_packet();
    t_stuffing();
    t_unstuff_err();
    t_long_eop();
    t_low_speed();
    t_odd_rate();
    t_change_flag();
    t_zero_rate();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule